// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block turns one operand field of a 16-bit stack-oriented instruction word into a complete description of the access that the field asks for. It takes the field code and a flag that tells it whether the field is the source slot (six bits wide) or the destination slot (five bits wide). It also takes the current contents of the eight general registers, the stack pointer, the program counter, the overflow/extra register and the extension word that the fetch path supplies. From these it reports the access class and any memory address. It also reports any direct operand value, whether the extension word was used, the stack pointer and program counter that follow the access, the extra lookup cycle, and whether a write back to the operand may take effect.

The decode is combinational, and the result is captured in a single register stage. A request presented with `in_valid` high on one rising edge appears on the outputs, with `out_valid` high, after that edge. The instruction sequencer calls the block once for the source field and then once for the destination field. It feeds the stack pointer and program counter produced by the first call into the second, so that a pop and an extension-word read in the source slot are visible to the destination slot.

Top module: `opdec_top`

## Requirements
- R1: Outputs are registered. A request sampled with `in_valid` high on a rising edge drives `out_valid` high after that edge, and `out_valid` is low after any edge where `in_valid` was low. Reset (synchronous, active high) clears every output to zero. `out_addr` is zero unless the kind is memory. `out_value` is zero for memory kind. `out_sel` is zero unless stated otherwise below.
- R2: Codes 0x00 to 0x07 give kind 0 (register) with `out_sel` equal to the code and `out_value` equal to that register. Registers A, B, C, X, Y, Z, I, J sit at `in_regs` bits [16k+15:16k] for k = 0..7.
- R3: Codes 0x08 to 0x0f give kind 1 (memory), with the address equal to register (code minus 8) and `out_sel` equal to that register index.
- R4: Codes 0x10 to 0x17 give kind 1, with the address equal to register (code minus 0x10) plus `in_ext`, modulo 2^16. `out_sel` carries the register index, and the extension word is used.
- R5: Code 0x18 in the destination slot is a push: kind 1, with the address and `out_sp_next` both equal to SP minus 1, modulo 2^16.
- R6: Code 0x18 in the source slot is a pop: kind 1, address SP, and `out_sp_next` equal to SP plus 1, modulo 2^16. Every other code leaves `out_sp_next` equal to SP.
- R7: Code 0x19 gives kind 1 at address SP. Code 0x1a gives kind 1 at SP plus `in_ext`, and uses the extension word.
- R8: Codes 0x1b, 0x1c and 0x1d give kind 2 (special) with `out_sel` 0, 1 and 2 and `out_value` SP, PC and EX respectively.
- R9: Code 0x1e gives kind 1 at address `in_ext`. Code 0x1f gives kind 3 (literal) with value `in_ext`. Both use the extension word.
- R10: In the source slot, codes 0x20 to 0x3f give kind 3 with value (code minus 0x21) modulo 2^16, covering 0xffff to 0x001e. In the destination slot only code bits [4:0] are decoded, and bit 5 has no effect.
- R11: `out_wr_en` is low for kind 3 and high for every other kind.
- R12: `out_ext_used` and `out_extra_cycle` are equal. `out_pc_next` equals PC plus `out_ext_used`, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decode request |
| in_code | input | 6 | Operand field code |
| in_is_src | input | 1 | 1 = source slot, 0 = destination slot |
| in_regs | input | 128 | Eight general registers, A in the low word |
| in_sp | input | 16 | Stack pointer |
| in_pc | input | 16 | Program counter, pointing at the next extension word |
| in_ex | input | 16 | Overflow/extra register |
| in_ext | input | 16 | Extension word read at PC |
| out_valid | output | 1 | Result valid |
| out_kind | output | 2 | 0 register, 1 memory, 2 special, 3 literal |
| out_sel | output | 3 | Register index or special index |
| out_addr | output | 16 | Effective memory address |
| out_value | output | 16 | Direct operand value |
| out_ext_used | output | 1 | Extension word consumed |
| out_extra_cycle | output | 1 | One extra lookup cycle |
| out_sp_next | output | 16 | Stack pointer after the access |
| out_pc_next | output | 16 | Program counter after the access |
| out_wr_en | output | 1 | Write back permitted |

## Verification
The block holds no state apart from its output stage, so any fault shows up on the one result that follows the faulty request. A wrong classification changes `out_kind` or `out_sel`. A wrong stack or extension-word bookkeeping changes `out_sp_next` or `out_pc_next` in that same result. The stimulus covers every source code and every destination code, including destination codes with bit 5 set. It also covers address, stack and program-counter wrap at the 16-bit boundary, so that a fault in a single code value or in the carry logic cannot go unseen.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    parameter int WORD_W    = 16;
    parameter int NUM_REGS  = 8;
    parameter int CODE_W    = 6;
    parameter int DST_W     = 5;
    parameter int REG_IDX_W = $clog2(NUM_REGS);
    parameter int LIT_BIAS  = 33;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        KIND_REG = 2'd0,
        KIND_MEM = 2'd1,
        KIND_SPR = 2'd2,
        KIND_LIT = 2'd3
    } kind_e;

    typedef enum logic [3:0] {
        MODE_REG,
        MODE_REG_IND,
        MODE_REG_OFS,
        MODE_PUSH,
        MODE_POP,
        MODE_PEEK,
        MODE_PICK,
        MODE_SPR,
        MODE_EXT_IND,
        MODE_EXT_LIT,
        MODE_SHORT_LIT
    } mode_e;

    typedef struct packed {
        mode_e                 mode;
        logic [REG_IDX_W-1:0]  idx;
        logic                  uses_ext;
        word_t                 lit;
    } class_t;

    typedef struct packed {
        kind_e                 kind;
        logic [REG_IDX_W-1:0]  sel;
        word_t                 addr;
        word_t                 value;
        logic                  ext_used;
        logic                  extra_cycle;
        word_t                 sp_next;
        word_t                 pc_next;
        logic                  wr_en;
    } result_t;

    function automatic word_t short_literal(input logic [CODE_W-1:0] c);
        return word_t'(c) - word_t'(LIT_BIAS);
    endfunction

endpackage

// File: rtl/opdec_classify.sv
module opdec_classify
    import opdec_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              is_src,
    output class_t            cls
);
    logic [CODE_W-1:0] eff;

    // destination fields are five bits wide; bit 5 is dropped there
    always_comb begin
        eff = is_src ? code : {{(CODE_W-DST_W){1'b0}}, code[DST_W-1:0]};
    end

    always_comb begin
        cls          = '0;
        cls.mode     = MODE_REG;
        cls.idx      = eff[REG_IDX_W-1:0];
        cls.uses_ext = 1'b0;
        cls.lit      = short_literal(eff);
        if (eff[CODE_W-1]) begin
            cls.mode = MODE_SHORT_LIT;
            cls.idx  = '0;
        end else begin
            case (eff[4:3])
                2'd0: cls.mode = MODE_REG;
                2'd1: cls.mode = MODE_REG_IND;
                2'd2: begin
                    cls.mode     = MODE_REG_OFS;
                    cls.uses_ext = 1'b1;
                end
                default: begin
                    cls.idx = '0;
                    case (eff[2:0])
                        3'd0: cls.mode = is_src ? MODE_POP : MODE_PUSH;
                        3'd1: cls.mode = MODE_PEEK;
                        3'd2: begin
                            cls.mode     = MODE_PICK;
                            cls.uses_ext = 1'b1;
                        end
                        3'd3: begin
                            cls.mode = MODE_SPR;
                            cls.idx  = REG_IDX_W'(0);
                        end
                        3'd4: begin
                            cls.mode = MODE_SPR;
                            cls.idx  = REG_IDX_W'(1);
                        end
                        3'd5: begin
                            cls.mode = MODE_SPR;
                            cls.idx  = REG_IDX_W'(2);
                        end
                        3'd6: begin
                            cls.mode     = MODE_EXT_IND;
                            cls.uses_ext = 1'b1;
                        end
                        default: begin
                            cls.mode     = MODE_EXT_LIT;
                            cls.uses_ext = 1'b1;
                        end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/opdec_resolve.sv
module opdec_resolve
    import opdec_pkg::*;
(
    input  class_t                     cls,
    input  logic [NUM_REGS*WORD_W-1:0] regs,
    input  word_t                      sp,
    input  word_t                      pc,
    input  word_t                      ex,
    input  word_t                      ext,
    output result_t                    res
);
    word_t reg_arr [NUM_REGS];
    word_t sel_reg;
    word_t spr_val;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_unpack
        assign reg_arr[k] = regs[k*WORD_W +: WORD_W];
    end

    assign sel_reg = reg_arr[cls.idx];

    always_comb begin
        case (cls.idx)
            REG_IDX_W'(0): spr_val = sp;
            REG_IDX_W'(1): spr_val = pc;
            default:       spr_val = ex;
        endcase
    end

    always_comb begin
        res             = '0;
        res.kind        = KIND_MEM;
        res.sel         = '0;
        res.sp_next     = sp;
        res.ext_used    = cls.uses_ext;
        res.extra_cycle = cls.uses_ext;
        res.pc_next     = pc + word_t'(cls.uses_ext);
        case (cls.mode)
            MODE_REG: begin
                res.kind  = KIND_REG;
                res.sel   = cls.idx;
                res.value = sel_reg;
            end
            MODE_REG_IND: begin
                res.sel  = cls.idx;
                res.addr = sel_reg;
            end
            MODE_REG_OFS: begin
                res.sel  = cls.idx;
                res.addr = sel_reg + ext;
            end
            MODE_PUSH: begin
                res.addr    = sp - word_t'(1);
                res.sp_next = sp - word_t'(1);
            end
            MODE_POP: begin
                res.addr    = sp;
                res.sp_next = sp + word_t'(1);
            end
            MODE_PEEK:    res.addr = sp;
            MODE_PICK:    res.addr = sp + ext;
            MODE_SPR: begin
                res.kind  = KIND_SPR;
                res.sel   = cls.idx;
                res.value = spr_val;
            end
            MODE_EXT_IND: res.addr = ext;
            MODE_EXT_LIT: begin
                res.kind  = KIND_LIT;
                res.value = ext;
            end
            default: begin
                res.kind  = KIND_LIT;
                res.value = cls.lit;
            end
        endcase
        res.wr_en = (res.kind != KIND_LIT);
    end
endmodule

// File: rtl/opdec_top.sv
module opdec_top
    import opdec_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [CODE_W-1:0]          in_code,
    input  logic                       in_is_src,
    input  logic [NUM_REGS*WORD_W-1:0] in_regs,
    input  logic [WORD_W-1:0]          in_sp,
    input  logic [WORD_W-1:0]          in_pc,
    input  logic [WORD_W-1:0]          in_ex,
    input  logic [WORD_W-1:0]          in_ext,
    output logic                       out_valid,
    output logic [1:0]                 out_kind,
    output logic [REG_IDX_W-1:0]       out_sel,
    output logic [WORD_W-1:0]          out_addr,
    output logic [WORD_W-1:0]          out_value,
    output logic                       out_ext_used,
    output logic                       out_extra_cycle,
    output logic [WORD_W-1:0]          out_sp_next,
    output logic [WORD_W-1:0]          out_pc_next,
    output logic                       out_wr_en
);
    class_t  cls;
    result_t comb_res;
    result_t res_q;
    logic    valid_q;

    opdec_classify u_classify (
        .code   (in_code),
        .is_src (in_is_src),
        .cls    (cls)
    );

    opdec_resolve u_resolve (
        .cls  (cls),
        .regs (in_regs),
        .sp   (in_sp),
        .pc   (in_pc),
        .ex   (in_ex),
        .ext  (in_ext),
        .res  (comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                res_q <= comb_res;
            end
        end
    end

    assign out_valid       = valid_q;
    assign out_kind        = res_q.kind;
    assign out_sel         = res_q.sel;
    assign out_addr        = res_q.addr;
    assign out_value       = res_q.value;
    assign out_ext_used    = res_q.ext_used;
    assign out_extra_cycle = res_q.extra_cycle;
    assign out_sp_next     = res_q.sp_next;
    assign out_pc_next     = res_q.pc_next;
    assign out_wr_en       = res_q.wr_en;
endmodule

// File: rtl/opdec_chk.sv
module opdec_chk
    import opdec_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic [CODE_W-1:0]          in_code,
    input logic                       in_is_src,
    input logic [NUM_REGS*WORD_W-1:0] in_regs,
    input logic [WORD_W-1:0]          in_sp,
    input logic [WORD_W-1:0]          in_pc,
    input logic [WORD_W-1:0]          in_ex,
    input logic [WORD_W-1:0]          in_ext,
    input logic                       out_valid,
    input logic [1:0]                 out_kind,
    input logic [REG_IDX_W-1:0]       out_sel,
    input logic [WORD_W-1:0]          out_addr,
    input logic [WORD_W-1:0]          out_value,
    input logic                       out_ext_used,
    input logic                       out_extra_cycle,
    input logic [WORD_W-1:0]          out_sp_next,
    input logic [WORD_W-1:0]          out_pc_next,
    input logic                       out_wr_en
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r5_push_predec: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_is_src && in_code[4:0] == 5'h18)
        |=> (out_sp_next == $past(in_sp) - 16'd1) && (out_addr == out_sp_next));

    a_r6_pop_postinc: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_is_src && in_code == 6'h18)
        |=> (out_addr == $past(in_sp)) && (out_sp_next == $past(in_sp) + 16'd1));

    a_r10_dst_no_short_lit: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_is_src) |=> (out_kind != 2'd3) || out_ext_used);

    a_r11_lit_no_write: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_wr_en == (out_kind != 2'd3)));

    a_r12_cycle_matches_ext: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_extra_cycle == out_ext_used));

    a_r12_pc_step: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_pc_next == $past(in_pc) + {15'd0, out_ext_used});
endmodule

bind opdec_top opdec_chk u_chk (.*);

// File: tb/opdec_top_tb.sv
module opdec_top_tb;
    import opdec_pkg::*;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [5:0]   in_code = '0;
    logic         in_is_src = 1'b0;
    logic [127:0] in_regs = '0;
    logic [15:0]  in_sp = '0, in_pc = '0, in_ex = '0, in_ext = '0;
    logic         out_valid;
    logic [1:0]   out_kind;
    logic [2:0]   out_sel;
    logic [15:0]  out_addr, out_value, out_sp_next, out_pc_next;
    logic         out_ext_used, out_extra_cycle, out_wr_en;

    typedef struct {
        logic [1:0]  kind;
        logic [2:0]  sel;
        logic [15:0] addr;
        logic [15:0] value;
        logic        ext;
        logic [15:0] sp_next;
        logic [15:0] pc_next;
        logic        wr_en;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    always #2 clk = ~clk;

    opdec_top u_dut (.*);

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [5:0] code, input logic src,
                                   input logic [127:0] regs,
                                   input logic [15:0] sp, pc, ex, ext);
        exp_t e;
        logic [5:0]  c;
        logic [15:0] r;
        c = src ? code : {1'b0, code[4:0]};
        r = regs[16*c[2:0] +: 16];
        e.kind = 2'd1; e.sel = 3'd0; e.addr = 16'd0; e.value = 16'd0;
        e.ext = 1'b0; e.sp_next = sp; e.tag = "R10";
        if (c < 6'd8) begin
            e.kind = 2'd0; e.sel = c[2:0]; e.value = r; e.tag = "R2";
        end else if (c < 6'd16) begin
            e.sel = c[2:0]; e.addr = r; e.tag = "R3";
        end else if (c < 6'd24) begin
            e.sel = c[2:0]; e.addr = r + ext; e.ext = 1'b1; e.tag = "R4";
        end else if (c == 6'd24) begin
            if (src) begin
                e.addr = sp; e.sp_next = sp + 16'd1; e.tag = "R6";
            end else begin
                e.addr = sp - 16'd1; e.sp_next = sp - 16'd1; e.tag = "R5";
            end
        end else if (c == 6'd25) begin
            e.addr = sp; e.tag = "R7";
        end else if (c == 6'd26) begin
            e.addr = sp + ext; e.ext = 1'b1; e.tag = "R7";
        end else if (c == 6'd27) begin
            e.kind = 2'd2; e.sel = 3'd0; e.value = sp; e.tag = "R8";
        end else if (c == 6'd28) begin
            e.kind = 2'd2; e.sel = 3'd1; e.value = pc; e.tag = "R8";
        end else if (c == 6'd29) begin
            e.kind = 2'd2; e.sel = 3'd2; e.value = ex; e.tag = "R8";
        end else if (c == 6'd30) begin
            e.addr = ext; e.ext = 1'b1; e.tag = "R9";
        end else if (c == 6'd31) begin
            e.kind = 2'd3; e.value = ext; e.ext = 1'b1; e.tag = "R9";
        end else begin
            e.kind = 2'd3; e.value = {10'd0, c} - 16'h0021;
        end
        if (!src && code[5]) e.tag = "R10";
        e.pc_next = pc + {15'd0, e.ext};
        e.wr_en   = (e.kind != 2'd3);
        return e;
    endfunction

    task automatic drive(input logic [5:0] code, input logic src,
                         input logic [127:0] regs,
                         input logic [15:0] sp, pc, ex, ext);
        @(negedge clk);
        in_valid = 1'b1; in_code = code; in_is_src = src; in_regs = regs;
        in_sp = sp; in_pc = pc; in_ex = ex; in_ext = ext;
        exp_q.push_back(model(code, src, regs, sp, pc, ex, ext));
    endtask

    function automatic logic [127:0] rand_regs();
        logic [127:0] v;
        for (int k = 0; k < 4; k++) v[32*k +: 32] = $urandom;
        return v;
    endfunction

    // monitor: compare each result against the head of the queue
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R1", "unexpected out_valid", 16'd1, 16'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, "kind",  {14'd0, out_kind}, {14'd0, e.kind});
                check(e.tag, "sel",   {13'd0, out_sel},  {13'd0, e.sel});
                check(e.tag, "addr",  out_addr,  e.addr);
                check(e.tag, "value", out_value, e.value);
                check(e.tag == "R5" ? "R5" : "R6", "sp_next", out_sp_next, e.sp_next);
                check("R11", "wr_en", {15'd0, out_wr_en}, {15'd0, e.wr_en});
                check("R12", "ext_used", {15'd0, out_ext_used}, {15'd0, e.ext});
                check("R12", "extra_cycle", {15'd0, out_extra_cycle}, {15'd0, e.ext});
                check("R12", "pc_next", out_pc_next, e.pc_next);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "reset out_valid", {15'd0, out_valid}, 16'd0);
        check("R1", "reset addr", out_addr, 16'd0);
        check("R1", "reset sp_next", out_sp_next, 16'd0);
        check("R1", "reset wr_en", {15'd0, out_wr_en}, 16'd0);
        rst = 1'b0;

        // every source code, twice with different register contents
        for (int pass = 0; pass < 2; pass++)
            for (int c = 0; c < 64; c++)
                drive(6'(c), 1'b1, rand_regs(), 16'($urandom), 16'($urandom),
                      16'($urandom), 16'($urandom));
        // every destination code, including bit 5 set (R10 ignore)
        for (int c = 0; c < 64; c++)
            drive(6'(c), 1'b0, rand_regs(), 16'($urandom), 16'($urandom),
                  16'($urandom), 16'($urandom));

        // wrap cases: R4 register+ext, R5 push at 0, R6 pop at top, R7 pick, R12 pc
        drive(6'h10, 1'b1, {112'd0, 16'hffff}, 16'h1234, 16'h0010, 16'h0, 16'h0002);
        drive(6'h18, 1'b0, rand_regs(), 16'h0000, 16'h0020, 16'h0, 16'h0);
        drive(6'h18, 1'b1, rand_regs(), 16'hffff, 16'h0030, 16'h0, 16'h0);
        drive(6'h1a, 1'b1, rand_regs(), 16'hfffe, 16'h0040, 16'h0, 16'h0005);
        drive(6'h1f, 1'b0, rand_regs(), 16'h0100, 16'hffff, 16'h0, 16'habcd);
        drive(6'h20, 1'b1, rand_regs(), 16'h0100, 16'hffff, 16'h0, 16'h0);
        drive(6'h3f, 1'b1, rand_regs(), 16'h0100, 16'hffff, 16'h0, 16'h0);

        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1: no result after an idle cycle
        check("R1", "idle out_valid", {15'd0, out_valid}, 16'd0);
        check("R1", "queue drained", 16'(exp_q.size()), 16'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule